// File: doc/BRIEF.md
# Converter Result Byte Sender

This block holds the latest finished conversion result and hands it to a byte-wide receiver, such as a serial transmitter's holding register, as two or three bytes. It works in one of two ways. In passive (direct) mode an outside master reads the bytes. An active-low chip-select and one active-low select per byte, both applied without any clock, turn on that byte's bus drivers. In active (handshake) mode the block takes over the select lines as outputs and sends the bytes itself. It paces each byte with a ready input from the receiver and marks each byte with a one-clock load strobe.

The pads are modelled as enables: `bus_oe_o` says which byte of `data_o` would be on the shared bus, and `ctl_oe_o` says whether the select and strobe lines are being driven. A result arrives with a one-cycle latch strobe. While a transfer is running, new results are dropped and the mode input is not looked at. The conversions outside the block go on as before.

Top module: `conv_byte_sender`

## Requirements
- R1: When `latch_i` is high and no transfer is running, `data_o` takes `result_i` at the closing clock edge. `status_o` is low only during such a cycle. `data_o` never changes after a cycle in which `status_o` was high.
- R2: A latch cycle that arrives while `mode_i` is high starts a transfer at the edge that ends that cycle.
- R3: A rising edge of `mode_i`, sampled at the clock, starts a transfer at that edge. If `mode_i` simply stays high, no new transfer starts without a fresh latch cycle.
- R4: During a transfer, `latch_i` leaves `data_o` unchanged and changes in `mode_i` neither end the transfer nor drop `ctl_oe_o`.
- R5: Once a transfer has started, the first rising edge that samples `ready_i` high starts the high byte. At that edge its select (bit NBYTES-1 of `ben_n_o`) goes low, and `ce_ld_n_o` goes low for exactly one clock period.
- R6: A byte's bus enable turns off at the first falling edge at which `ready_i` is high, counted from one full period after that byte started. Its select returns high at the next rising edge.
- R7: Bytes go out in order from the highest index down to index 0, with at most one select low at a time. With `ready_i` held high, each select stays low two periods and each bus enable stays on one and a half periods. Successive bytes follow each other without a gap.
- R8: While `ready_i` is low, the block waits. It starts no first byte, and an active byte keeps its select low and its bus enable on.
- R9: At the rising edge after the low byte is released, the transfer ends and latching and mode sensing work again. If `mode_i` is low, `ctl_oe_o` drops.
- R10: In passive mode (`ctl_oe_o` low), bit i of `bus_oe_o` is high exactly when `dir_ce_n_i` and bit i of `dir_ben_n_i` are both low, combinationally. `ben_n_o` and `ce_ld_n_o` read high.
- R11: With `mode_i` high and no transfer running, the select and strobe outputs are driven high and no byte is on the bus, whatever the passive inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Selects active sending; its rising edge starts a transfer |
| ready_i | input | 1 | Receiver can accept a byte |
| latch_i | input | 1 | One-cycle strobe: a new result is ready |
| result_i | input | 8*NBYTES | Finished conversion result; the top byte carries polarity, over-range and the top data bits |
| dir_ce_n_i | input | 1 | Passive-mode chip select, active low |
| dir_ben_n_i | input | NBYTES | Passive-mode per-byte selects, active low |
| data_o | output | 8*NBYTES | Held result; byte i sits at bits 8i+7..8i |
| status_o | output | 1 | Low in the cycle whose closing edge updates the held result |
| ctl_oe_o | output | 1 | Select and strobe lines are driven by the block |
| ce_ld_n_o | output | 1 | Load strobe to the receiver, active low |
| ben_n_o | output | NBYTES | Per-byte selects in active mode, active low |
| bus_oe_o | output | NBYTES | Per-byte bus driver enables |

## Verification
A wrong sequencer state appears at the select outputs at the next rising edge: a byte that is skipped, repeated or out of order shows a wrong low bit in `ben_n_o`. A strobe stuck low shows on `ce_ld_n_o` one period later. A faulty acknowledge capture appears half a clock later, as a bus enable that fails to turn off at the falling edge or turns off during a stall. A latch that is not blocked shows up as a changed `data_o` once the transfer has ended. Each stall length and each entry path is therefore checked at both clock phases of every cycle of the transfer.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      SND_IDLE  = 2'd0,
      SND_ARMED = 2'd1,
      SND_BYTE  = 2'd2
   } snd_state_t;

endpackage

// File: rtl/cbs_result_reg.sv
`timescale 1ns/1ps
module cbs_result_reg #(
   parameter int DW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          latch_i,
   input  logic          inhibit_i,
   input  logic [DW-1:0] result_i,
   output logic [DW-1:0] data_o,
   output logic          status_o
);

   logic          take;
   logic [DW-1:0] data_q;

   assign take     = latch_i && !inhibit_i;
   assign status_o = !take;
   assign data_o   = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (take) begin
         data_q <= result_i;
      end
   end

   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      status_o |=> $stable(data_q)); // R1

   AST_LATCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_i |=> $stable(data_q)); // R4

endmodule

// File: rtl/cbs_send_fsm.sv
`timescale 1ns/1ps
module cbs_send_fsm
   import cbs_pkg::*;
#(
   parameter int NBYTES = 3,
   localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_i,
   input  logic             ready_i,
   input  logic             latch_i,
   input  logic             acked_i,
   output logic             hs_o,
   output logic             active_o,
   output logic [IDX_W-1:0] cur_o,
   output logic             ld_n_o,
   output logic             tok_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

   snd_state_t       state_q;
   logic [IDX_W-1:0] cur_q;
   logic             ld_n_q;
   logic             tok_q;
   logic             mode_q;
   logic             start_req;

   assign start_req = (latch_i && mode_i) || (mode_i && !mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SND_IDLE;
         cur_q   <= '0;
         ld_n_q  <= 1'b1;
         tok_q   <= 1'b0;
         mode_q  <= 1'b0;
      end else begin
         mode_q <= mode_i;
         unique case (state_q)
            SND_IDLE: begin
               if (start_req) state_q <= SND_ARMED;
            end
            SND_ARMED: begin
               if (ready_i) begin
                  state_q <= SND_BYTE;
                  cur_q   <= LAST_IDX;
                  ld_n_q  <= 1'b0;
                  tok_q   <= ~tok_q;
               end
            end
            SND_BYTE: begin
               ld_n_q <= 1'b1;
               if (acked_i) begin
                  if (cur_q == '0) begin
                     state_q <= SND_IDLE;
                  end else begin
                     cur_q  <= cur_q - IDX_W'(1);
                     ld_n_q <= 1'b0;
                     tok_q  <= ~tok_q;
                  end
               end
            end
            default: state_q <= SND_IDLE;
         endcase
      end
   end

   assign hs_o     = (state_q != SND_IDLE);
   assign active_o = (state_q == SND_BYTE);
   assign cur_o    = cur_q;
   assign ld_n_o   = ld_n_q;
   assign tok_o    = tok_q;

   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_n_q |=> ld_n_q); // R5

   AST_ENTRY_BY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SND_IDLE && latch_i && mode_i) |=> hs_o); // R2

   AST_ENTRY_BY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SND_IDLE && mode_i && !mode_q) |=> hs_o); // R3

   AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SND_BYTE && !acked_i) |=> (state_q == SND_BYTE && $stable(cur_q))); // R8

   AST_DESCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SND_BYTE && acked_i && cur_q != '0) |=> (cur_q == $past(cur_q) - IDX_W'(1))); // R7

   AST_EXIT_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SND_BYTE && acked_i && cur_q == '0) |=> (state_q == SND_IDLE)); // R9

endmodule

// File: rtl/cbs_ack_sampler.sv
`timescale 1ns/1ps
module cbs_ack_sampler (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic ld_n_i,
   input  logic ready_i,
   input  logic tok_i,
   output logic acked_o
);

   logic ack_tok_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_tok_q <= 1'b0;
      end else if (active_i && ld_n_i && ready_i) begin
         ack_tok_q <= tok_i;
      end
   end

   assign acked_o = active_i && (ack_tok_q == tok_i);

endmodule

// File: rtl/cbs_pad_ctrl.sv
`timescale 1ns/1ps
module cbs_pad_ctrl #(
   parameter int NBYTES = 3,
   localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_i,
   input  logic              mode_i,
   input  logic              active_i,
   input  logic [IDX_W-1:0]  cur_i,
   input  logic              acked_i,
   input  logic              ld_n_i,
   input  logic              dir_ce_n_i,
   input  logic [NBYTES-1:0] dir_ben_n_i,
   output logic              ctl_oe_o,
   output logic              ce_ld_n_o,
   output logic [NBYTES-1:0] ben_n_o,
   output logic [NBYTES-1:0] bus_oe_o
);

   assign ctl_oe_o  = hs_i || mode_i;
   assign ce_ld_n_o = ctl_oe_o ? ld_n_i : 1'b1;

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      logic sel;
      assign sel         = active_i && (cur_i == IDX_W'(i));
      assign ben_n_o[i]  = ctl_oe_o ? !sel : 1'b1;
      assign bus_oe_o[i] = ctl_oe_o ? (sel && !acked_i)
                                    : (!dir_ce_n_i && !dir_ben_n_i[i]);
   end

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ben_n_o)); // R7

   AST_BUS_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_i && (|bus_oe_o)) |-> (|(bus_oe_o & ~ben_n_o))); // R6

   AST_DRIVEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_oe_o && !hs_i) |-> (bus_oe_o == '0 && (&ben_n_o) && ce_ld_n_o)); // R11

endmodule

// File: rtl/conv_byte_sender.sv
`timescale 1ns/1ps
module conv_byte_sender
   import cbs_pkg::*;
#(
   parameter int NBYTES = 3,
   localparam int DW    = BYTE_W * NBYTES,
   localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i,
   input  logic              ready_i,
   input  logic              latch_i,
   input  logic [DW-1:0]     result_i,
   input  logic              dir_ce_n_i,
   input  logic [NBYTES-1:0] dir_ben_n_i,
   output logic [DW-1:0]     data_o,
   output logic              status_o,
   output logic              ctl_oe_o,
   output logic              ce_ld_n_o,
   output logic [NBYTES-1:0] ben_n_o,
   output logic [NBYTES-1:0] bus_oe_o
);

   if (NBYTES < 2 || NBYTES > 3) begin : g_bad_cfg
      $error("conv_byte_sender: NBYTES must be 2 or 3");
   end

   logic             hs;
   logic             active;
   logic [IDX_W-1:0] cur;
   logic             ld_n;
   logic             tok;
   logic             acked;

   cbs_result_reg #(.DW(DW)) i_result (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch_i   (latch_i),
      .inhibit_i (hs),
      .result_i  (result_i),
      .data_o    (data_o),
      .status_o  (status_o)
   );

   cbs_send_fsm #(.NBYTES(NBYTES)) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode_i),
      .ready_i  (ready_i),
      .latch_i  (latch_i),
      .acked_i  (acked),
      .hs_o     (hs),
      .active_o (active),
      .cur_o    (cur),
      .ld_n_o   (ld_n),
      .tok_o    (tok)
   );

   cbs_ack_sampler i_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .ld_n_i   (ld_n),
      .ready_i  (ready_i),
      .tok_i    (tok),
      .acked_o  (acked)
   );

   cbs_pad_ctrl #(.NBYTES(NBYTES)) i_pads (
      .clk         (clk),
      .rst_n       (rst_n),
      .hs_i        (hs),
      .mode_i      (mode_i),
      .active_i    (active),
      .cur_i       (cur),
      .acked_i     (acked),
      .ld_n_i      (ld_n),
      .dir_ce_n_i  (dir_ce_n_i),
      .dir_ben_n_i (dir_ben_n_i),
      .ctl_oe_o    (ctl_oe_o),
      .ce_ld_n_o   (ce_ld_n_o),
      .ben_n_o     (ben_n_o),
      .bus_oe_o    (bus_oe_o)
   );

endmodule

// File: tb/test_conv_byte_sender.sv
`timescale 1ns/1ps
module test_conv_byte_sender;

   localparam int NB = 3;
   localparam int DW = 8 * NB;

   logic          clk;
   logic          rst_n;
   logic          mode_i;
   logic          ready_i;
   logic          latch_i;
   logic [DW-1:0] result_i;
   logic          dir_ce_n_i;
   logic [NB-1:0] dir_ben_n_i;
   logic [DW-1:0] data_o;
   logic          status_o;
   logic          ctl_oe_o;
   logic          ce_ld_n_o;
   logic [NB-1:0] ben_n_o;
   logic [NB-1:0] bus_oe_o;

   int n_cmp = 0;
   int n_bad = 0;

   conv_byte_sender #(.NBYTES(NB)) i_conv_byte_sender (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .ready_i(ready_i),
      .latch_i(latch_i), .result_i(result_i), .dir_ce_n_i(dir_ce_n_i),
      .dir_ben_n_i(dir_ben_n_i), .data_o(data_o), .status_o(status_o),
      .ctl_oe_o(ctl_oe_o), .ce_ld_n_o(ce_ld_n_o), .ben_n_o(ben_n_o),
      .bus_oe_o(bus_oe_o)
   );

   initial begin
      clk = 1'b0;
      forever #5 clk = ~clk;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [NB-1:0] sel_low(input int b);
      logic [NB-1:0] m;
      m = '1;
      m[b] = 1'b0;
      return m;
   endfunction

   function automatic logic [NB-1:0] one_at(input int b);
      logic [NB-1:0] m;
      m = '0;
      m[b] = 1'b1;
      return m;
   endfunction

   // Passive-mode latch, then a rising mode edge starts the transfer; ends at E+3
   task automatic rise_entry(input logic [DW-1:0] val);
      latch_i  = 1'b1;
      result_i = val;
      #1 check("R1 status low in latch cycle", 32'(status_o), 32'd0);
      @(posedge clk); #1 latch_i = 1'b0;
      #2 check("R1 data loaded", 32'(data_o), 32'(val));
      check("R1 status high", 32'(status_o), 32'd1);
      check("R9 passive before entry", 32'(ctl_oe_o), 32'd0);
      mode_i = 1'b1;
      @(posedge clk); #3 check("R3 driven after mode rise", 32'(ctl_oe_o), 32'd1);
      check("R3 no select yet", 32'(ben_n_o), 32'(sel_low(0) | one_at(0)));
      latch_i  = 1'b1;
      result_i = ~val;
   endtask

   // Latch with mode already high; ends at E+3 with mode dropped
   task automatic latch_entry(input logic [DW-1:0] val);
      latch_i  = 1'b1;
      result_i = val;
      #1 check("R1 status low in latch cycle", 32'(status_o), 32'd0);
      @(posedge clk); #3 check("R2 data loaded at entry", 32'(data_o), 32'(val));
      check("R2 driven after latch entry", 32'(ctl_oe_o), 32'd1);
      result_i = ~val;
      mode_i   = 1'b0;
   endtask

   task automatic run_bytes(input int sf, input int sa, input logic [DW-1:0] val, input logic mode_end);
      for (int i = 0; i < sf; i++) begin
         @(posedge clk); #1 latch_i = 1'b0;
         #2 check("R8 no byte while ready low", 32'(ben_n_o), 32'((1 << NB) - 1));
         check("R8 strobe idle while waiting", 32'(ce_ld_n_o), 32'd1);
         check("R4 transfer held regardless of mode", 32'(ctl_oe_o), 32'd1);
      end
      ready_i = 1'b1;
      for (int b = NB - 1; b >= 0; b--) begin
         @(posedge clk); #1 latch_i = 1'b0;
         #2 check("R7 select order", 32'(ben_n_o), 32'(sel_low(b)));
         check("R5 strobe low at byte start", 32'(ce_ld_n_o), 32'd0);
         check("R7 bus enable at start", 32'(bus_oe_o), 32'(one_at(b)));
         @(posedge clk); #1 ready_i = (sa == 0);
         #2 check("R5 strobe back high after one period", 32'(ce_ld_n_o), 32'd1);
         check("R7 select held second period", 32'(ben_n_o), 32'(sel_low(b)));
         check("R6 bus still on before falling edge", 32'(bus_oe_o), 32'(one_at(b)));
         #4 check("R6 bus off at falling edge when ready", 32'(bus_oe_o), (sa == 0) ? 32'd0 : 32'(one_at(b)));
         check("R6 select low until rising edge", 32'(ben_n_o), 32'(sel_low(b)));
         for (int k = 1; k <= sa; k++) begin
            @(posedge clk); #1 ready_i = (k == sa);
            #2 check("R8 select held in stall", 32'(ben_n_o), 32'(sel_low(b)));
            check("R8 strobe high in stall", 32'(ce_ld_n_o), 32'd1);
            check("R8 bus held in stall", 32'(bus_oe_o), 32'(one_at(b)));
            #4 check("R8 bus after stall falling edge", 32'(bus_oe_o), (k == sa) ? 32'd0 : 32'(one_at(b)));
         end
      end
      @(posedge clk); #3 check("R9 selects released", 32'(ben_n_o), 32'((1 << NB) - 1));
      check("R9 bus off after last byte", 32'(bus_oe_o), 32'd0);
      check("R9 strobe idle after last byte", 32'(ce_ld_n_o), 32'd1);
      check("R9 line drive follows mode", 32'(ctl_oe_o), 32'(mode_end));
      check("R4 latch ignored during transfer", 32'(data_o), 32'(val));
   endtask

   task automatic no_reentry;
      dir_ce_n_i  = 1'b0;
      dir_ben_n_i = '0;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); #3 check("R3 held mode does not restart", 32'(ben_n_o), 32'((1 << NB) - 1));
         check("R3 no strobe with held mode", 32'(ce_ld_n_o), 32'd1);
         check("R11 passive inputs ignored when driven", 32'(bus_oe_o), 32'd0);
      end
      dir_ce_n_i  = 1'b1;
      dir_ben_n_i = '1;
      ready_i     = 1'b0;
   endtask

   initial begin
      rst_n       = 1'b0;
      mode_i      = 1'b0;
      ready_i     = 1'b0;
      latch_i     = 1'b0;
      result_i    = '0;
      dir_ce_n_i  = 1'b1;
      dir_ben_n_i = '1;
      #22 rst_n = 1'b1;
      @(posedge clk); #3;
      check("R1 reset data", 32'(data_o), 32'd0);
      check("R1 reset status", 32'(status_o), 32'd1);
      check("R10 reset passive", 32'(ctl_oe_o), 32'd0);
      check("R10 reset selects high", 32'(ben_n_o), 32'((1 << NB) - 1));
      check("R10 reset strobe high", 32'(ce_ld_n_o), 32'd1);

      for (int v = 0; v < (1 << (NB + 1)); v++) begin
         logic [NB-1:0] exp_oe;
         {dir_ce_n_i, dir_ben_n_i} = (NB + 1)'(v);
         #1;
         exp_oe = dir_ce_n_i ? '0 : ~dir_ben_n_i;
         check("R10 passive bus enable", 32'(bus_oe_o), 32'(exp_oe));
         check("R10 passive selects read high", 32'(ben_n_o), 32'((1 << NB) - 1));
      end
      dir_ce_n_i  = 1'b1;
      dir_ben_n_i = '1;
      @(posedge clk); #3;

      for (int sf = 0; sf < 3; sf++) begin
         for (int sa = 0; sa < 3; sa++) begin
            logic [DW-1:0] x1;
            logic [DW-1:0] x2;
            x1 = DW'(32'h00A5C3E1 + (sf * 3 + sa) * 32'h00051B37);
            x2 = DW'(32'h003C1F07 ^ (x1 << 1));
            rise_entry(x1);
            run_bytes(sf, sa, x1, 1'b1);
            no_reentry();
            latch_entry(x2);
            run_bytes(sa, sf, x2, 1'b0);
            ready_i = 1'b0;
            @(posedge clk); #3;
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule